// File: doc/BRIEF.md
# Prioritised Background Window Compositor

This block decides, pixel by pixel, whether one of four rectangular background windows of an on-screen menu covers the current display position, or whether the drop shadow of such a window does. The position comes in as a character row, a character column and the pixel and line offsets inside the 12-pixel by 18-line character cell. The block turns these into absolute pixel coordinates and tests each window's rectangle and its shadow rectangle. It then picks the highest-priority window that covers the pixel and emits a registered hit flag, a 3-bit color and a shadow flag for the video mixer downstream.

Each window holds an inclusive row range, an inclusive column range, an enable bit, a shadow-enable bit, a fill color, a shadow color, and 2-bit codes for the shadow width and height. All of these are loaded through a byte-wide write port. One command address clears every window's enable bit at once and leaves the other fields untouched.

Top module: `bgw_compositor`

## Requirements
- R1: After reset all three outputs are 0. A new position affects `win_hit`, `win_color` and `win_shadow` exactly one clock edge after it is presented, and not before.
- R2: A pixel inside an enabled window's body gives hit=1, color=fill color and shadow=0. The body spans absolute x from col_start*12 to col_end*12+11 and y from row_start*18 to row_end*18+17, with both bounds inclusive. A pixel covered by no window gives hit=0, color=000 and shadow=0.
- R3: A window whose row start exceeds its row end, or whose column start exceeds its column end, covers no pixel, neither with its body nor with its shadow.
- R4: A window whose enable bit is 0 covers no pixel.
- R5: Writing a byte with bit 0 set to address 16 clears the enable bit of all four windows in one write. Every other field keeps its value, so setting the enable bit again restores the same window.
- R6: Where windows overlap, the window with the lower index wins, from window 0 down to window 3. A window covers a pixel if either its body or its shadow covers it.
- R7: The shadow rectangle is the body shifted right by a width of 2, 4, 6 or 8 pixels for width code 00, 01, 10 or 11.
- R8: The shadow rectangle is the body shifted down by a height of 2, 4, 6 or 8 lines for height code 00, 01, 10 or 11.
- R9: Only pixels in the shifted rectangle and outside the window's own body are shadow. They are shown only while the window's shadow-enable bit is set, and they give hit=1, shadow=1 and color=the window's shadow color.
- R10: The body of a higher-priority window overrides the shadow of a lower-priority one. Every shadow color resets to 000.
- R11: Register map for window w: address 4w holds row_end in bits 7:4 and row_start in bits 3:0. Address 4w+1 holds enable in bit 7, shadow-enable in bit 6 and col_start in bits 4:0. Address 4w+2 holds the fill color in bits 7:5 and col_end in bits 4:0. Address 4w+3 holds the width code in bits 7:6, the height code in bits 5:4 and the shadow color in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| pos_row | input | 4 | Character row of the current pixel |
| pos_col | input | 5 | Character column of the current pixel |
| pos_px | input | 4 | Pixel offset inside the cell (0..11) |
| pos_ln | input | 5 | Line offset inside the cell (0..17) |
| win_hit | output | 1 | Some window or shadow covers the pixel |
| win_color | output | 3 | Fill or shadow color of the winning window |
| win_shadow | output | 1 | The winning coverage is a shadow |

## Verification
The bench probes the pixels just inside and just outside each shadow edge. A design that sized the shadow from the code without the +1 step, or that shifted only one edge, shows or loses the shadow one or two pixels off. Windows with inverted ranges, and windows that are disabled or cleared, are probed where their bodies would lie, which catches a design that compares only one dimension or clears only one enable bit. Overlaps put a full-screen low-priority window under higher ones, and a higher body over a lower shadow, so a reversed priority scan shows up as a wrong color. A shadow color that was never written is read out to catch a bad reset value.

// File: rtl/bgw_pkg.sv
package bgw_pkg;
    localparam int NWIN      = 4;
    localparam int ROW_W     = 4;
    localparam int COL_W     = 5;
    localparam int PX_W      = 4;
    localparam int LN_W      = 5;
    localparam int CELL_W    = 12;
    localparam int CELL_H    = 18;
    localparam int CLR_W     = 3;
    localparam int CODE_W    = 2;
    localparam int REGS_PER_WIN = 4;
    localparam int CTRL_ADDR = REGS_PER_WIN * NWIN;
    localparam int A_W       = $clog2(CTRL_ADDR + 1);
    localparam int MAX_STEP  = 2 * (2 ** CODE_W);
    localparam int X_W       = $clog2((2 ** COL_W) * CELL_W + MAX_STEP + 1);
    localparam int Y_W       = $clog2((2 ** ROW_W) * CELL_H + MAX_STEP + 1);

    typedef struct packed {
        logic              en;
        logic              shen;
        logic [ROW_W-1:0]  row_s;
        logic [ROW_W-1:0]  row_e;
        logic [COL_W-1:0]  col_s;
        logic [COL_W-1:0]  col_e;
        logic [CLR_W-1:0]  fill;
        logic [CLR_W-1:0]  shcol;
        logic [CODE_W-1:0] sw;
        logic [CODE_W-1:0] sh;
    } win_cfg_t;

    typedef struct packed {
        logic             hit;
        logic [CLR_W-1:0] color;
        logic             shadow;
    } pix_t;
endpackage

// File: rtl/bgw_regfile.sv
module bgw_regfile
    import bgw_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [A_W-1:0] wr_addr,
    input  logic [7:0]     wr_data,
    output win_cfg_t       cfg_o [NWIN]
);
    typedef struct packed {
        win_cfg_t [NWIN-1:0] win;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == A_W'(CTRL_ADDR)) begin
                if (wr_data[0]) begin
                    for (int w = 0; w < NWIN; w++) begin
                        st_d.win[w].en = 1'b0;
                    end
                end
            end else begin
                for (int w = 0; w < NWIN; w++) begin
                    if (wr_addr == A_W'(REGS_PER_WIN * w)) begin
                        st_d.win[w].row_s = wr_data[ROW_W-1:0];
                        st_d.win[w].row_e = wr_data[4 +: ROW_W];
                    end
                    if (wr_addr == A_W'(REGS_PER_WIN * w + 1)) begin
                        st_d.win[w].en    = wr_data[7];
                        st_d.win[w].shen  = wr_data[6];
                        st_d.win[w].col_s = wr_data[COL_W-1:0];
                    end
                    if (wr_addr == A_W'(REGS_PER_WIN * w + 2)) begin
                        st_d.win[w].fill  = wr_data[7 -: CLR_W];
                        st_d.win[w].col_e = wr_data[COL_W-1:0];
                    end
                    if (wr_addr == A_W'(REGS_PER_WIN * w + 3)) begin
                        st_d.win[w].sw    = wr_data[7 -: CODE_W];
                        st_d.win[w].sh    = wr_data[5 -: CODE_W];
                        st_d.win[w].shcol = wr_data[CLR_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_out
        assign cfg_o[g] = st_q.win[g];
    end

    logic [NWIN-1:0] en_vec;
    always_comb begin
        for (int w = 0; w < NWIN; w++) begin
            en_vec[w] = st_q.win[w].en;
        end
    end

    // R5: a clear command leaves no window enabled
    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_W'(CTRL_ADDR) && wr_data[0]) |=> (en_vec == '0));
endmodule

// File: rtl/bgw_win_hit.sv
module bgw_win_hit
    import bgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  win_cfg_t         cfg,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    input  logic [PX_W-1:0]  px,
    input  logic [LN_W-1:0]  ln,
    output logic             body,
    output logic             shade
);
    logic [X_W-1:0] x, xs, xe, sx;
    logic [Y_W-1:0] y, ys, ye, sy;
    logic           valid, in_shift;

    always_comb begin
        x  = X_W'(col) * X_W'(CELL_W) + X_W'(px);
        y  = Y_W'(row) * Y_W'(CELL_H) + Y_W'(ln);
        xs = X_W'(cfg.col_s) * X_W'(CELL_W);
        xe = X_W'(cfg.col_e) * X_W'(CELL_W) + X_W'(CELL_W - 1);
        ys = Y_W'(cfg.row_s) * Y_W'(CELL_H);
        ye = Y_W'(cfg.row_e) * Y_W'(CELL_H) + Y_W'(CELL_H - 1);
        sx = X_W'({cfg.sw, 1'b0}) + X_W'(2);
        sy = Y_W'({cfg.sh, 1'b0}) + Y_W'(2);
        valid = cfg.en && (cfg.row_s <= cfg.row_e) && (cfg.col_s <= cfg.col_e);
        body  = valid && (x >= xs) && (x <= xe) && (y >= ys) && (y <= ye);
        in_shift = (x >= xs + sx) && (x <= xe + sx) && (y >= ys + sy) && (y <= ye + sy);
        shade = valid && cfg.shen && !body && in_shift;
    end

    // R3: inverted ranges never cover a pixel
    a_r3_inverted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.row_s > cfg.row_e) || (cfg.col_s > cfg.col_e)) |-> !(body || shade));
endmodule

// File: rtl/bgw_prio.sv
module bgw_prio
    import bgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  win_cfg_t        cfg [NWIN],
    input  logic [NWIN-1:0] body,
    input  logic [NWIN-1:0] shade,
    output pix_t            pix
);
    logic [NWIN-1:0] grant;

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (!found && (body[w] || shade[w])) begin
                grant[w] = 1'b1;
                found    = 1'b1;
            end
        end
        pix = '0;
        for (int w = 0; w < NWIN; w++) begin
            if (grant[w]) begin
                pix.hit    = 1'b1;
                pix.shadow = !body[w];
                pix.color  = body[w] ? cfg[w].fill : cfg[w].shcol;
            end
        end
    end

    // R6: at most one window is selected
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6: the top-priority body always decides the pixel
    a_r6_top_body_wins: assert property (@(posedge clk) disable iff (!rst_n)
        body[0] |-> (pix.hit && !pix.shadow && pix.color == cfg[0].fill));
endmodule

// File: rtl/bgw_compositor.sv
module bgw_compositor
    import bgw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [A_W-1:0]   wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [ROW_W-1:0] pos_row,
    input  logic [COL_W-1:0] pos_col,
    input  logic [PX_W-1:0]  pos_px,
    input  logic [LN_W-1:0]  pos_ln,
    output logic             win_hit,
    output logic [CLR_W-1:0] win_color,
    output logic             win_shadow
);
    win_cfg_t        cfg [NWIN];
    logic [NWIN-1:0] body, shade;
    pix_t            pix;
    pix_t            out_d, out_q;

    bgw_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        bgw_win_hit u_hit (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[g]),
            .row   (pos_row),
            .col   (pos_col),
            .px    (pos_px),
            .ln    (pos_ln),
            .body  (body[g]),
            .shade (shade[g])
        );
    end

    bgw_prio u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg),
        .body  (body),
        .shade (shade),
        .pix   (pix)
    );

    always_comb begin
        out_d = pix;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign win_hit    = out_q.hit;
    assign win_color  = out_q.color;
    assign win_shadow = out_q.shadow;

    // R9: a shadow pixel is always a hit
    a_r9_shadow_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
        win_shadow |-> win_hit);
    // R2: a miss carries black and no shadow
    a_r2_quiet_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !win_hit |-> (win_color == '0 && !win_shadow));
endmodule

// File: tb/sim_bgw_compositor.sv
module sim_bgw_compositor;
    import bgw_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [A_W-1:0]   wr_addr = '0;
    logic [7:0]       wr_data = '0;
    logic [ROW_W-1:0] pos_row = '0;
    logic [COL_W-1:0] pos_col = '0;
    logic [PX_W-1:0]  pos_px = '0;
    logic [LN_W-1:0]  pos_ln = '0;
    logic             win_hit;
    logic [CLR_W-1:0] win_color;
    logic             win_shadow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bgw_compositor u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pos_row(pos_row), .pos_col(pos_col), .pos_px(pos_px), .pos_ln(pos_ln),
        .win_hit(win_hit), .win_color(win_color), .win_shadow(win_shadow)
    );

    task automatic cmp(input string tag, input logic eh, input logic [2:0] ec, input logic es);
        n_chk++;
        if (win_hit !== eh || win_color !== ec || win_shadow !== es) begin
            n_bad++;
            $display("FAIL %s actual hit=%b color=%b shadow=%b expected hit=%b color=%b shadow=%b",
                     tag, win_hit, win_color, win_shadow, eh, ec, es);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input int r, input int c, input int p, input int l,
                         input logic eh, input logic [2:0] ec, input logic es, input string tag);
        @(negedge clk);
        pos_row = ROW_W'(r); pos_col = COL_W'(c); pos_px = PX_W'(p); pos_ln = LN_W'(l);
        @(negedge clk);
        cmp(tag, eh, ec, es);
    endtask

    task automatic t_reset();
        cmp("R1 reset outputs", 1'b0, 3'b000, 1'b0);
        probe(2, 4, 0, 0, 1'b0, 3'b000, 1'b0, "R4 nothing enabled after reset");
    endtask

    task automatic t_body();
        wr(0, 8'h32); wr(1, 8'hC4); wr(2, 8'hA6); wr(3, 8'h63);
        probe(2, 4, 0, 0, 1'b1, 3'b101, 1'b0, "R2 top-left corner R11");
        probe(3, 6, 11, 17, 1'b1, 3'b101, 1'b0, "R2 bottom-right corner");
        probe(2, 3, 11, 0, 1'b0, 3'b000, 1'b0, "R2 left of body");
    endtask

    task automatic t_shadow_size();
        probe(2, 7, 0, 0, 1'b0, 3'b000, 1'b0, "R8 right band above offset");
        probe(2, 7, 0, 6, 1'b1, 3'b011, 1'b1, "R9 right band shadow");
        probe(2, 7, 3, 6, 1'b1, 3'b011, 1'b1, "R7 last shadow pixel width 4");
        probe(2, 7, 4, 6, 1'b0, 3'b000, 1'b0, "R7 past shadow width 4");
        probe(4, 4, 4, 0, 1'b1, 3'b011, 1'b1, "R9 bottom band shadow");
        probe(4, 4, 4, 5, 1'b1, 3'b011, 1'b1, "R8 last shadow line height 6");
        probe(4, 4, 4, 6, 1'b0, 3'b000, 1'b0, "R8 past shadow height 6");
        probe(4, 4, 3, 0, 1'b0, 3'b000, 1'b0, "R7 bottom band left edge");
    endtask

    task automatic t_latency();
        probe(0, 0, 0, 0, 1'b0, 3'b000, 1'b0, "R1 miss before step");
        @(negedge clk);
        pos_row = 4'd2; pos_col = 5'd5; pos_px = 4'd0; pos_ln = 5'd0;
        #1;
        cmp("R1 no change before edge", 1'b0, 3'b000, 1'b0);
        @(negedge clk);
        cmp("R1 change after one edge", 1'b1, 3'b101, 1'b0);
    endtask

    task automatic t_shadow_en();
        wr(1, 8'h84);
        probe(2, 7, 0, 6, 1'b0, 3'b000, 1'b0, "R9 shadow disabled");
        wr(1, 8'hC4);
        probe(2, 7, 0, 6, 1'b1, 3'b011, 1'b1, "R9 shadow re-enabled");
    endtask

    task automatic t_inverted();
        wr(4, 8'h45); wr(5, 8'h80); wr(6, 8'h5D);
        probe(5, 0, 0, 0, 1'b0, 3'b000, 1'b0, "R3 inverted rows");
        probe(4, 3, 0, 0, 1'b0, 3'b000, 1'b0, "R3 inverted rows other line");
        wr(4, 8'h54); wr(5, 8'h8A); wr(6, 8'h49);
        probe(4, 9, 0, 0, 1'b0, 3'b000, 1'b0, "R3 inverted cols");
        probe(4, 10, 0, 0, 1'b0, 3'b000, 1'b0, "R3 inverted cols start");
        wr(5, 8'h89); wr(6, 8'h4A);
        probe(4, 9, 0, 0, 1'b1, 3'b010, 1'b0, "R3 corrected range shows");
    endtask

    task automatic t_enable();
        wr(5, 8'h09);
        probe(4, 9, 0, 0, 1'b0, 3'b000, 1'b0, "R4 enable bit low");
    endtask

    task automatic t_priority();
        wr(4, 8'h11); wr(5, 8'hC1); wr(6, 8'h43); wr(7, 8'h04);
        probe(2, 4, 0, 0, 1'b1, 3'b101, 1'b0, "R10 higher body over lower shadow");
        probe(1, 4, 0, 2, 1'b1, 3'b100, 1'b1, "R7 width code 00 shadow");
        wr(8, 8'hE0); wr(9, 8'h80); wr(10, 8'h3D);
        wr(12, 8'h10); wr(13, 8'h80); wr(14, 8'hC1);
        probe(0, 0, 0, 0, 1'b1, 3'b001, 1'b0, "R6 window 2 over window 3");
        probe(2, 7, 0, 6, 1'b1, 3'b011, 1'b1, "R6 shadow of window 0 over body of window 2");
        probe(1, 2, 0, 0, 1'b1, 3'b010, 1'b0, "R6 window 1 over window 2");
        probe(10, 20, 5, 5, 1'b1, 3'b001, 1'b0, "R6 full screen window alone");
    endtask

    task automatic t_clear();
        wr(16, 8'h01);
        probe(0, 0, 0, 0, 1'b0, 3'b000, 1'b0, "R5 full screen cleared");
        probe(2, 4, 0, 0, 1'b0, 3'b000, 1'b0, "R5 window 0 cleared");
        probe(1, 2, 0, 0, 1'b0, 3'b000, 1'b0, "R5 window 1 cleared");
        wr(13, 8'hC0);
        probe(0, 2, 0, 2, 1'b1, 3'b000, 1'b1, "R10 reset shadow color");
        wr(9, 8'h80);
        probe(0, 0, 0, 0, 1'b1, 3'b001, 1'b0, "R5 fields kept after clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_body();
        t_shadow_size();
        t_latency();
        t_shadow_en();
        t_inverted();
        t_enable();
        t_priority();
        t_clear();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule